// File: doc/BRIEF.md
# Sleep-State Clock Enable Controller

This block tracks whether a small processor subsystem is running or asleep and produces the clock-enable signals for it. When the core reports that it has executed a wait-for-interrupt instruction, the block drops the enable for the core and memory clock, so no code runs, and moves to its sleep state. It returns to the running state as soon as any interrupt line is both pending and enabled. The clocks themselves are not generated here: the outputs are enables that a glitch-free gate cell further down the clock tree consumes. The system clock source and its frequency stay the same in both states, so a peripheral that keeps its clock in sleep runs at the frequency it had before.

Each peripheral has one bit in a run-time enable set and one bit in a sleep-time enable set. While running, the peripheral enables always follow the run-time set. While asleep, they follow the sleep-time set when automatic gating is switched on, and stay on the run-time set when it is off. A status output reports the current state.

Wake-up is decided combinationally from the interrupt inputs. The state change takes effect at the next rising edge of the free-running clock. An asynchronous active-low reset is released synchronously inside the block.

Top module: `sleep_clk_gate_ctrl`

## Requirements
- R1: During and after reset the block is in the running state: `in_sleep` = 0 and `core_clk_en` = 1.
- R2: In the running state, with `wfi_req` = 1 and no line having both `irq_pending[i]` and `irq_enable[i]` = 1, the state becomes asleep at the next rising clock edge (`in_sleep` = 1, `core_clk_en` = 0).
- R3: If `wfi_req` = 1 while some line has both `irq_pending[i]` = 1 and `irq_enable[i]` = 1, the block stays in the running state.
- R4: A pending line whose `irq_enable` bit is 0 does not wake the block; it stays asleep.
- R5: While asleep, any line i with `irq_pending[i]` = 1 and `irq_enable[i]` = 1, including the lowest and highest line, returns the block to the running state at the next rising clock edge.
- R6: In the running state `periph_clk_en` equals `run_en` for either value of `auto_gate_en`.
- R7: Asleep with `auto_gate_en` = 1, `periph_clk_en` equals `sleep_en`.
- R8: Asleep with `auto_gate_en` = 0, `periph_clk_en` equals `run_en`.
- R9: `core_clk_en` is always the inverse of `in_sleep` (1 in the running state, 0 asleep).
- R10: While asleep, a further `wfi_req` without an enabled pending line leaves the block asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_req | input | 1 | Core executed a wait-for-interrupt |
| irq_pending | input | N_IRQ | Interrupt pending flags |
| irq_enable | input | N_IRQ | Interrupt enable flags |
| auto_gate_en | input | 1 | Select the sleep-time enable set while asleep |
| run_en | input | N_PERIPH | Per-peripheral enables for the running state |
| sleep_en | input | N_PERIPH | Per-peripheral enables for sleep with automatic gating |
| core_clk_en | output | 1 | Core and memory clock enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| in_sleep | output | 1 | Current state: 1 asleep, 0 running |

## Verification
The sleep request is tried with no interrupt pending, with a pending line whose enable is clear, and with an enabled pending line, which separates a real entry from a blocked one and shows that masking is honoured. Wake-up is driven through the lowest and highest interrupt lines so a reduction that drops an end bit is caught. Distinct bit patterns in the two enable sets, with automatic gating toggled in both states, tell apart which set drives the peripheral enables in each state.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic {
    PM_RUN   = 1'b0,
    PM_SLEEP = 1'b1
  } pm_state_e;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_pending,
  input  logic [N_IRQ-1:0] irq_enable,
  output logic             wake
);
  logic [N_IRQ-1:0] armed;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign armed[i] = irq_pending[i] & irq_enable[i];
  end

  assign wake = |armed;
endmodule

// File: rtl/pmc_state_fsm.sv
module pmc_state_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wfi_req,
  input  logic      wake,
  output pm_state_e state
);
  pm_state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:   if (wfi_req && !wake) state_d = PM_SLEEP;
      PM_SLEEP: if (wake)             state_d = PM_RUN;
      default:                        state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assign state = state_q;

  p_enter_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && wfi_req && !wake) |=> (state_q == PM_SLEEP));

  p_blocked_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && wake) |=> (state_q == PM_RUN));

  p_stay_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP && !wake) |=> (state_q == PM_SLEEP));

  p_wake_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP && wake) |=> (state_q == PM_RUN));
endmodule

// File: rtl/pmc_periph_mux.sv
module pmc_periph_mux #(
  parameter int N_PERIPH = 16
) (
  input  logic                sleeping,
  input  logic                auto_gate_en,
  input  logic [N_PERIPH-1:0] run_en,
  input  logic [N_PERIPH-1:0] sleep_en,
  output logic [N_PERIPH-1:0] periph_clk_en
);
  logic use_sleep_set;

  assign use_sleep_set = sleeping & auto_gate_en;

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_periph
    assign periph_clk_en[p] = use_sleep_set ? sleep_en[p] : run_en[p];
  end
endmodule

// File: rtl/sleep_clk_gate_ctrl.sv
module sleep_clk_gate_ctrl
  import pmc_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int N_PERIPH   = 16,
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wfi_req,
  input  logic [N_IRQ-1:0]    irq_pending,
  input  logic [N_IRQ-1:0]    irq_enable,
  input  logic                auto_gate_en,
  input  logic [N_PERIPH-1:0] run_en,
  input  logic [N_PERIPH-1:0] sleep_en,
  output logic                core_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                in_sleep
);
  logic      rst_n_sync;
  logic      wake;
  pm_state_e state;

  pmc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pmc_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .wake        (wake)
  );

  pmc_state_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wfi_req (wfi_req),
    .wake    (wake),
    .state   (state)
  );

  assign in_sleep    = (state == PM_SLEEP);
  assign core_clk_en = (state == PM_RUN);

  pmc_periph_mux #(.N_PERIPH(N_PERIPH)) u_mux (
    .sleeping      (in_sleep),
    .auto_gate_en  (auto_gate_en),
    .run_en        (run_en),
    .sleep_en      (sleep_en),
    .periph_clk_en (periph_clk_en)
  );

  p_core_en_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    core_clk_en != in_sleep);

  p_run_set_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_sleep |-> (periph_clk_en == run_en));

  p_reset_run_r1: assert property (@(posedge clk)
    !rst_n_sync |-> (core_clk_en && !in_sleep));
endmodule

// File: tb/sleep_clk_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_clk_gate_ctrl_tb_top;
  localparam int N_IRQ    = 8;
  localparam int N_PERIPH = 16;
  localparam logic [N_PERIPH-1:0] RUN_PAT   = 16'hA5C3;
  localparam logic [N_PERIPH-1:0] SLEEP_PAT = 16'h1E60;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                wfi_req;
  logic [N_IRQ-1:0]    irq_pending;
  logic [N_IRQ-1:0]    irq_enable;
  logic                auto_gate_en;
  logic [N_PERIPH-1:0] run_en;
  logic [N_PERIPH-1:0] sleep_en;
  logic                core_clk_en;
  logic [N_PERIPH-1:0] periph_clk_en;
  logic                in_sleep;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  sleep_clk_gate_ctrl #(.N_IRQ(N_IRQ), .N_PERIPH(N_PERIPH)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wfi_req       (wfi_req),
    .irq_pending   (irq_pending),
    .irq_enable    (irq_enable),
    .auto_gate_en  (auto_gate_en),
    .run_en        (run_en),
    .sleep_en      (sleep_en),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .in_sleep      (in_sleep)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wfi_req = 1'b0; irq_pending = '0; irq_enable = '0;
    auto_gate_en = 1'b1; run_en = RUN_PAT; sleep_en = SLEEP_PAT;
    step(3);
    check("R1 in_sleep in reset", {31'd0, in_sleep}, 32'd0);
    check("R1 core_clk_en in reset", {31'd0, core_clk_en}, 32'd1);
    rst_n = 1'b1;
    step(4);
    check("R1 in_sleep after reset", {31'd0, in_sleep}, 32'd0);
    check("R6 periph in run, auto on", {16'd0, periph_clk_en}, {16'd0, RUN_PAT});
  endtask

  task automatic t_run_ignores_auto;
    auto_gate_en = 1'b0; #1;
    check("R6 periph in run, auto off", {16'd0, periph_clk_en}, {16'd0, RUN_PAT});
    auto_gate_en = 1'b1; #1;
    check("R6 periph in run, auto on", {16'd0, periph_clk_en}, {16'd0, RUN_PAT});
  endtask

  task automatic t_enter_sleep;
    wfi_req = 1'b1; irq_pending = '0; irq_enable = 8'hFF;
    step(1);
    wfi_req = 1'b0;
    check("R2 in_sleep after wfi", {31'd0, in_sleep}, 32'd1);
    check("R9 core_clk_en asleep", {31'd0, core_clk_en}, 32'd0);
  endtask

  task automatic t_sleep_sets;
    auto_gate_en = 1'b1; #1;
    check("R7 periph asleep, auto on", {16'd0, periph_clk_en}, {16'd0, SLEEP_PAT});
    auto_gate_en = 1'b0; #1;
    check("R8 periph asleep, auto off", {16'd0, periph_clk_en}, {16'd0, RUN_PAT});
    auto_gate_en = 1'b1; #1;
  endtask

  task automatic t_masked_pending;
    irq_pending = 8'h10; irq_enable = 8'hEF; wfi_req = 1'b1;
    step(3);
    check("R4 masked line keeps sleep", {31'd0, in_sleep}, 32'd1);
    check("R10 repeated wfi keeps sleep", {31'd0, core_clk_en}, 32'd0);
    wfi_req = 1'b0;
  endtask

  task automatic t_wake(input int line);
    irq_enable = '0; irq_pending = '0;
    irq_pending[line] = 1'b1; irq_enable[line] = 1'b1;
    step(1);
    check($sformatf("R5 wake via line %0d", line), {31'd0, in_sleep}, 32'd0);
    check("R9 core_clk_en after wake", {31'd0, core_clk_en}, 32'd1);
    irq_pending = '0;
  endtask

  task automatic t_blocked_entry;
    irq_pending = 8'h04; irq_enable = 8'h04; wfi_req = 1'b1;
    step(2);
    check("R3 wfi with enabled pending stays run", {31'd0, in_sleep}, 32'd0);
    wfi_req = 1'b0; irq_pending = '0;
  endtask

  initial begin
    t_reset();
    t_run_ignores_auto();
    t_enter_sleep();
    t_sleep_sets();
    t_masked_pending();
    t_wake(4);
    t_blocked_entry();
    t_enter_sleep();
    t_wake(0);
    run_en = 16'h00FF; sleep_en = 16'hF00F;
    t_enter_sleep();
    auto_gate_en = 1'b1; #1;
    check("R7 periph asleep, new pattern", {16'd0, periph_clk_en}, 32'h0000F00F);
    t_wake(N_IRQ-1);
    check("R6 periph back in run", {16'd0, periph_clk_en}, 32'h000000FF);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule